// File: doc/BRIEF.md
# Status Register and Write-Protect Gate

This block sits behind the command decoder of a serial memory slave. It owns an 8-bit status byte and the write-enable latch. It also decides, every cycle, whether a memory write to the presented address and a status-byte write may go ahead. The decoder sends it single-cycle pulses: latch set, latch clear, status-write start (sent when the status-write opcode is recognised) and status-write commit (sent when the eight data bits have arrived). It also sends the data byte, the level of the write-protect pin and the current memory write address.

The bits that would keep their value across power loss are ordinary flops with a reset value of zero. The status byte is always available for the read path. The two permission flags are combinational from state and inputs, so the decoder can consult them in the same cycle it would perform the write.

Top module: `sr_guard`

## Requirements
- R1: The status byte is laid out as bit 7 protect-enable, bits 6..4 spare (writable and readable), bits 3..2 block-select (bit 3 high, bit 2 low), bit 1 the write-enable latch, and bit 0, which always reads 0.
- R2: After reset the status byte is 0x00 and both permission flags are 0.
- R3: A latch-set pulse makes bit 1 read 1 from the next cycle. A latch-clear pulse makes it read 0. When both pulses arrive in the same cycle, clear wins.
- R4: A committed, permitted status write loads bits 7..2 from data bits 7..2. Data bits 1..0 have no effect.
- R5: While the latch is 0, both permission flags are 0 and a status-write commit leaves the status byte unchanged.
- R6: For a 19-bit address, block-select 00 protects nothing, 01 protects 0x60000..0x7FFFF, 10 protects 0x40000..0x7FFFF and 11 protects all addresses. The memory flag is 1 exactly when the latch is 1 and the address is outside the protected range.
- R7: With the latch set, the status flag is 0 only when protect-enable is 1 and the protect pin is low. A commit while the flag is 0 leaves the status byte unchanged.
- R8: The protect pin level is captured on the start pulse and governs the status flag and the commit until that commit, whatever the pin does in between.
- R9: A status write never changes the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wel_set_i | input | 1 | Latch-set command pulse |
| wel_clr_i | input | 1 | Latch-clear command pulse |
| srw_start_i | input | 1 | Status-write command recognised |
| srw_commit_i | input | 1 | Status-write data byte complete |
| srw_data_i | input | 8 | Status-write data byte |
| wp_level_i | input | 1 | Write-protect pin level (low = protect) |
| wr_addr_i | input | ADDR_W | Memory write address |
| status_o | output | 8 | Status byte for the read path |
| mem_wr_ok_o | output | 1 | Memory write to wr_addr_i permitted |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
The bench builds the block with its defaults: a 19-bit address and the pin-sampling variant of the protect gate. The 19-bit width makes the exact boundary addresses 0x3FFFF/0x40000, 0x5FFFF/0x60000 and 0x7FFFF reachable, so each range edge is probed on both sides. The sampling variant makes it possible to test a pin change between start and commit in both directions.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

   localparam int unsigned SR_W = 8;

   // Bit positions in the status byte; the read path decodes these
   localparam int unsigned POS_WPEN  = 7;
   localparam int unsigned POS_SPARE = 4;
   localparam int unsigned POS_BP    = 2;
   localparam int unsigned POS_WEL   = 1;

   typedef enum logic [1:0] {
      BLK_NONE    = 2'b00,
      BLK_QUARTER = 2'b01,
      BLK_HALF    = 2'b10,
      BLK_ALL     = 2'b11
   } blk_sel_e;

   typedef struct packed {
      logic       wpen;
      logic [2:0] spare;
      blk_sel_e   bp;
   } cfg_bits_t;

   localparam int unsigned CFG_W = $bits(cfg_bits_t);

   function automatic logic [SR_W-1:0] pack_status(cfg_bits_t c, logic wel);
      logic [SR_W-1:0] s;
      s = '0;
      s[POS_WPEN]            = c.wpen;
      s[POS_SPARE +: 3]      = c.spare;
      s[POS_BP +: 2]         = c.bp;
      s[POS_WEL]             = wel;
      return s;
   endfunction

   function automatic cfg_bits_t unpack_cfg(logic [SR_W-1:0] d);
      cfg_bits_t c;
      c.wpen  = d[POS_WPEN];
      c.spare = d[POS_SPARE +: 3];
      c.bp    = blk_sel_e'(d[POS_BP +: 2]);
      return c;
   endfunction

endpackage

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic wel_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    wel_o <= 1'b0;
      else if (clr_i) wel_o <= 1'b0;
      else if (set_i) wel_o <= 1'b1;
   end

   // R3
   wel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && !clr_i) |=> wel_o);

   // R3
   wel_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !wel_o);

   // R9
   wel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i && !clr_i) |=> $stable(wel_o));

endmodule

// File: rtl/sr_cfg_store.sv
module sr_cfg_store
   import sr_guard_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            commit_i,
   input  logic            allow_i,
   input  logic [SR_W-1:0] data_i,
   output cfg_bits_t       cfg_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cfg_o <= '0;
      else if (commit_i && allow_i)   cfg_o <= unpack_cfg(data_i);
   end

   // R5 R7
   cfg_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && !allow_i) |=> $stable(cfg_o));

   // R4
   cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && allow_i) |=> (cfg_o.wpen == $past(data_i[POS_WPEN])));

endmodule

// File: rtl/sr_wp_gate.sv
module sr_wp_gate #(
   parameter bit WP_SAMPLE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic commit_i,
   input  logic wp_pin_i,
   input  logic wpen_i,
   input  logic wel_i,
   output logic ok_o
);

   logic wp_use;

   generate
      if (WP_SAMPLE) begin : g_sampled
         logic cmd_open;
         logic wp_held;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cmd_open <= 1'b0;
               wp_held  <= 1'b1;
            end else if (start_i && !commit_i) begin
               cmd_open <= 1'b1;
               wp_held  <= wp_pin_i;
            end else if (commit_i) begin
               cmd_open <= 1'b0;
            end
         end
         assign wp_use = cmd_open ? wp_held : wp_pin_i;

         // R8
         wp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cmd_open && !commit_i && !start_i) |=> $stable(wp_held));
      end else begin : g_live
         assign wp_use = wp_pin_i;
      end
   endgenerate

   assign ok_o = wel_i && !(wpen_i && !wp_use);

endmodule

// File: rtl/sr_range_prot.sv
module sr_range_prot
   import sr_guard_pkg::*;
#(
   parameter int unsigned ADDR_W = 19
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  blk_sel_e          bp_i,
   input  logic              wel_i,
   output logic              ok_o
);

   localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
   localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("sr_range_prot: ADDR_W must be at least 2");
      end
   endgenerate

   logic guarded;

   always_comb begin
      unique case (bp_i)
         BLK_NONE:    guarded = 1'b0;
         BLK_QUARTER: guarded = (addr_i >= QTR_BASE);
         BLK_HALF:    guarded = (addr_i >= HALF_BASE);
         default:     guarded = 1'b1;
      endcase
   end

   assign ok_o = wel_i && !guarded;

endmodule

// File: rtl/sr_guard.sv
module sr_guard
   import sr_guard_pkg::*;
#(
   parameter int unsigned ADDR_W    = 19,
   parameter bit          WP_SAMPLE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wel_set_i,
   input  logic              wel_clr_i,
   input  logic              srw_start_i,
   input  logic              srw_commit_i,
   input  logic [7:0]        srw_data_i,
   input  logic              wp_level_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   output logic [7:0]        status_o,
   output logic              mem_wr_ok_o,
   output logic              sr_wr_ok_o
);

   generate
      if (SR_W != 8) begin : g_bad_sr
         $error("sr_guard: status byte must be 8 bits");
      end
   endgenerate

   logic      wel;
   cfg_bits_t cfg;

   sr_wel_latch u_wel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wel_set_i),
      .clr_i  (wel_clr_i),
      .wel_o  (wel)
   );

   sr_wp_gate #(.WP_SAMPLE(WP_SAMPLE)) u_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (srw_start_i),
      .commit_i (srw_commit_i),
      .wp_pin_i (wp_level_i),
      .wpen_i   (cfg.wpen),
      .wel_i    (wel),
      .ok_o     (sr_wr_ok_o)
   );

   sr_cfg_store u_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .commit_i (srw_commit_i),
      .allow_i  (sr_wr_ok_o),
      .data_i   (srw_data_i),
      .cfg_o    (cfg)
   );

   sr_range_prot #(.ADDR_W(ADDR_W)) u_range (
      .addr_i (wr_addr_i),
      .bp_i   (cfg.bp),
      .wel_i  (wel),
      .ok_o   (mem_wr_ok_o)
   );

   assign status_o = pack_status(cfg, wel);

   // R5
   no_wel_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !status_o[POS_WEL] |-> (!mem_wr_ok_o && !sr_wr_ok_o));

   // R6
   all_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[POS_BP +: 2] == 2'b11) |-> !mem_wr_ok_o);

   // R1
   bit0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srw_commit_i |=> !status_o[0]);

endmodule

// File: tb/sr_guard_tb.sv
module sr_guard_tb;

   localparam int unsigned AW = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          set_p = 1'b0, clr_p = 1'b0, st_p = 1'b0, cm_p = 1'b0;
   logic [7:0]    data = '0;
   logic          wp = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    status;
   logic          mem_ok, sr_ok;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   sr_guard #(.ADDR_W(AW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .wel_set_i(set_p), .wel_clr_i(clr_p),
      .srw_start_i(st_p), .srw_commit_i(cm_p), .srw_data_i(data),
      .wp_level_i(wp), .wr_addr_i(addr),
      .status_o(status), .mem_wr_ok_o(mem_ok), .sr_wr_ok_o(sr_ok)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic pulse(input bit do_set, input bit do_clr);
      @(negedge clk);
      set_p = do_set; clr_p = do_clr;
      @(negedge clk);
      set_p = 1'b0; clr_p = 1'b0;
   endtask

   // start with pin at wp_a, commit with pin at wp_b; returns flag seen at commit
   task automatic wr_status(input logic [7:0] d, input logic wp_a, input logic wp_b,
                            output logic ok_seen);
      @(negedge clk);
      st_p = 1'b1; data = d; wp = wp_a;
      @(negedge clk);
      st_p = 1'b0; cm_p = 1'b1; wp = wp_b;
      #1 ok_seen = sr_ok;
      @(negedge clk);
      cm_p = 1'b0; wp = 1'b1;
   endtask

   task automatic t_reset;
      #1;
      chk("R2 status", status, 8'h00);
      chk("R2 mem flag", mem_ok, 1'b0);
      chk("R2 sr flag", sr_ok, 1'b0);
   endtask

   task automatic t_no_latch;
      logic ok;
      wr_status(8'hFC, 1'b1, 1'b1, ok);
      chk("R5 sr flag at commit", ok, 1'b0);
      chk("R5 status unchanged", status, 8'h00);
      addr = 19'h00000; #1;
      chk("R5 mem flag", mem_ok, 1'b0);
   endtask

   task automatic t_latch;
      pulse(1'b1, 1'b0);
      chk("R3 set", status, 8'h02);
      pulse(1'b0, 1'b1);
      chk("R3 clear", status, 8'h00);
      pulse(1'b1, 1'b0);
      pulse(1'b1, 1'b1);
      chk("R3 clear wins", status, 8'h00);
      pulse(1'b1, 1'b0);
      chk("R3 set again", status, 8'h02);
   endtask

   task automatic t_write;
      logic ok;
      wr_status(8'hFF, 1'b1, 1'b1, ok);
      chk("R4 write FF", status, 8'hFE);
      chk("R1 bit0 reads 0", status[0], 1'b0);
      wr_status(8'h01, 1'b1, 1'b1, ok);
      chk("R9 latch kept, bits1..0 ignored", status, 8'h02);
      wr_status(8'h70, 1'b1, 1'b1, ok);
      chk("R1 spare bits", status, 8'h72);
      wr_status(8'h00, 1'b1, 1'b1, ok);
   endtask

   task automatic probe(input string req, input logic [AW-1:0] a, input logic exp);
      @(negedge clk);
      addr = a; #1;
      chk(req, mem_ok, exp);
   endtask

   task automatic t_blocks;
      logic ok;
      wr_status(8'h04, 1'b1, 1'b1, ok);
      probe("R6 q 5FFFF", 19'h5FFFF, 1'b1);
      probe("R6 q 60000", 19'h60000, 1'b0);
      probe("R6 q 7FFFF", 19'h7FFFF, 1'b0);
      wr_status(8'h08, 1'b1, 1'b1, ok);
      probe("R6 h 3FFFF", 19'h3FFFF, 1'b1);
      probe("R6 h 40000", 19'h40000, 1'b0);
      wr_status(8'h0C, 1'b1, 1'b1, ok);
      probe("R6 all 00000", 19'h00000, 1'b0);
      wr_status(8'h00, 1'b1, 1'b1, ok);
      probe("R6 none 7FFFF", 19'h7FFFF, 1'b1);
      pulse(1'b0, 1'b1);
      probe("R5 latch clear blocks", 19'h00010, 1'b0);
      pulse(1'b1, 1'b0);
   endtask

   task automatic t_pin;
      logic ok;
      wr_status(8'h80, 1'b1, 1'b1, ok);
      chk("R7 set protect-enable", status, 8'h82);
      @(negedge clk); wp = 1'b0; #1;
      chk("R7 flag low pin", sr_ok, 1'b0);
      wp = 1'b1; #1;
      chk("R7 flag high pin", sr_ok, 1'b1);
      wr_status(8'h00, 1'b0, 1'b0, ok);
      chk("R7 blocked write", status, 8'h82);
   endtask

   task automatic t_sample;
      logic ok;
      wr_status(8'h84, 1'b1, 1'b0, ok);
      chk("R8 flag uses start level", ok, 1'b1);
      chk("R8 write with start level high", status, 8'h86);
      wr_status(8'h00, 1'b0, 1'b1, ok);
      chk("R8 flag held low", ok, 1'b0);
      chk("R8 write with start level low", status, 8'h86);
   endtask

   initial begin
      #(200000 * 8);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_no_latch();
      t_latch();
      t_write();
      t_blocks();
      t_pin();
      t_sample();
      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule